// File: doc/BRIEF.md
# Processor Debug Mode Controller

This block decides when one processor core stops and waits for a debug host, and when it runs again. It watches the core's trap reports and several event lines: an error-mode trap, the end of a single step, a breakpoint found on the system bus, and halt notices from peer cores. It merges them into one entry decision. On entry it raises a pipeline hold and captures the program counter and the next program counter. It can also freeze the timers, and it sends a one-cycle notice to the peer cores. Debug mode proper begins only once the core reports that its pipeline is idle.

The debug host reaches the block through a small register port. Each request gets its response one cycle later. The control, trap-selection and command/status registers answer at any time. The captured PC values and a window onto core state answer only while debug mode is in effect. A resume command releases the core. A single-step flag makes the core return to debug mode after one instruction.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A reported trap of type 0x81 (the trap-always instruction with software number 1) while running raises `pipe_hold` in the next cycle. Another software trap such as 0x82 does not, unless it is selected under R5.
- R2: A reported trap of type 0x0B (hardware breakpoint or watchpoint hit) while running raises `pipe_hold` in the next cycle.
- R3: A write to address 0x2 with bit 0 set (break now) while running raises `pipe_hold` in the next cycle.
- R4: `err_trap` high while running raises `pipe_hold` in the next cycle.
- R5: Trap selection. Bit 0 of the control register at 0x0 makes every reported trap cause entry. Bit i of the selection register at 0x1 makes trap type i cause entry, for i below MW. A trap that is not selected is ignored.
- R6: Bit 1 of a write to 0x2 sets or clears the step flag. `step_done` causes entry only while the step flag is set.
- R7: Any bit of `peer_halt_in` causes entry. `peer_halt_out` is high for exactly one cycle, the first cycle of `pipe_hold`.
- R8: `bus_bkpt_hit` while running causes entry.
- R9: `pc` and `npc` are captured in the cycle the trigger is seen. They stay unchanged until resume, even if further triggers arrive. They read back at 0x4 (PC) and 0x5 (nPC).
- R10: `timer_freeze` equals `pipe_hold` AND bit 1 of the control register.
- R11: `dbg_mode` rises in the cycle after `core_idle` is seen high while the hold is pending. Addresses 0x4, 0x5 and 0x8–0xF are gated. Outside `dbg_mode` they answer with `reg_err`, read data 0, no `core_acc_en` and no effect. Addresses 0x0–0x2 always answer with `reg_ack`. Every response comes one cycle after its request.
- R12: A write to 0x2 with bit 2 set while in `dbg_mode` drops `pipe_hold` and `dbg_mode` in the next cycle. Reading 0x2 returns the step flag in bit 0, hold-pending-not-idle in bit 1 and `dbg_mode` in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| trap_valid | input | 1 | Core reports a trap this cycle |
| trap_type | input | 8 | Type of the reported trap |
| err_trap | input | 1 | Trap would put the core into error mode |
| step_done | input | 1 | Core finished one stepped instruction |
| bus_bkpt_hit | input | 1 | System-bus breakpoint matched |
| peer_halt_in | input | NPEER | Entry notices from peer cores |
| core_idle | input | 1 | Core pipeline has drained under hold |
| pc | input | PCW | Core program counter |
| npc | input | PCW | Core next program counter |
| reg_req | input | 1 | Host register request |
| reg_we | input | 1 | Request is a write |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, one cycle after request |
| reg_ack | output | 1 | Request accepted |
| reg_err | output | 1 | Request refused |
| core_acc_en | output | 1 | Core-state window access strobe |
| core_acc_we | output | 1 | Window access is a write |
| core_acc_idx | output | 3 | Window register index |
| core_acc_wdata | output | DW | Window write data |
| core_acc_rdata | input | DW | Window read data from the core |
| pipe_hold | output | 1 | Hold the core pipeline |
| timer_freeze | output | 1 | Freeze timers and watchdog |
| dbg_mode | output | 1 | Debug mode in effect |
| peer_halt_out | output | 1 | One-cycle entry notice to peers |
| saved_pc | output | PCW | Captured PC |
| saved_npc | output | PCW | Captured nPC |

## Verification
The hardest state to reach is the window between entry and halt: `pipe_hold` is already high but `core_idle` has not yet come, and gated state must still be refused. The bench holds `core_idle` low, forces entry with a break-now write, and then makes gated and status reads in that window. It then raises `core_idle` and repeats the accesses. Single-step re-entry is also hard to reach, because the step flag and the resume must go out in one write from a halted core. The bench halts the core first, issues that combined command, and pulses `step_done` afterwards.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
    localparam int TT_W = 8;
    localparam logic [TT_W-1:0] TT_SW_BKPT  = 8'h81;
    localparam logic [TT_W-1:0] TT_HW_WATCH = 8'h0B;

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_TSEL = 4'h1;
    localparam logic [3:0] A_CMD  = 4'h2;
    localparam logic [3:0] A_SPC  = 4'h4;
    localparam logic [3:0] A_SNPC = 4'h5;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HALTING = 2'd1,
        ST_HALTED  = 2'd2
    } dstate_e;
endpackage

// File: rtl/dbgc_trig.sv
module dbgc_trig
    import dbgc_pkg::*;
#(
    parameter int MW    = 32,
    parameter int NPEER = 3
) (
    input  logic            trap_valid,
    input  logic [TT_W-1:0] trap_type,
    input  logic            err_trap,
    input  logic            step_done,
    input  logic            step_armed,
    input  logic            bus_bkpt_hit,
    input  logic [NPEER-1:0] peer_halt_in,
    input  logic            brk_now,
    input  logic            trap_all,
    input  logic [MW-1:0]   trap_sel,
    output logic            trig
);
    logic [MW-1:0] sel_hit;

    for (genvar i = 0; i < MW; i++) begin : g_sel
        assign sel_hit[i] = trap_sel[i] && (trap_type == TT_W'(i));
    end

    logic trap_hit;
    always_comb begin
        trap_hit = trap_valid && (trap_all
                                 || (trap_type == TT_SW_BKPT)
                                 || (trap_type == TT_HW_WATCH)
                                 || (|sel_hit));
        trig = trap_hit
            || err_trap
            || (step_done && step_armed)
            || bus_bkpt_hit
            || (|peer_halt_in)
            || brk_now;
    end
endmodule

// File: rtl/dbgc_core.sv
module dbgc_core
    import dbgc_pkg::*;
#(
    parameter int PCW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trig,
    input  logic           resume,
    input  logic           core_idle,
    input  logic           freeze_en,
    input  logic [PCW-1:0] pc,
    input  logic [PCW-1:0] npc,
    output logic           pipe_hold,
    output logic           halting,
    output logic           halted,
    output logic           timer_freeze,
    output logic           peer_out,
    output logic [PCW-1:0] saved_pc,
    output logic [PCW-1:0] saved_npc
);
    typedef struct packed {
        dstate_e        st;
        logic [PCW-1:0] spc;
        logic [PCW-1:0] snpc;
        logic           pulse;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        unique case (st_q.st)
            ST_RUN: begin
                if (trig) begin
                    st_d.st    = ST_HALTING;
                    st_d.spc   = pc;
                    st_d.snpc  = npc;
                    st_d.pulse = 1'b1;
                end
            end
            ST_HALTING: begin
                if (core_idle) st_d.st = ST_HALTED;
            end
            ST_HALTED: begin
                if (resume) st_d.st = ST_RUN;
            end
            default: st_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{st: ST_RUN, spc: '0, snpc: '0, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pipe_hold    = (st_q.st != ST_RUN);
    assign halting      = (st_q.st == ST_HALTING);
    assign halted       = (st_q.st == ST_HALTED);
    assign timer_freeze = pipe_hold && freeze_en;
    assign peer_out     = st_q.pulse;
    assign saved_pc     = st_q.spc;
    assign saved_npc    = st_q.snpc;
endmodule

// File: rtl/dbgc_port.sv
module dbgc_port
    import dbgc_pkg::*;
#(
    parameter int MW  = 32,
    parameter int PCW = 32,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic           we,
    input  logic [3:0]     addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic           ack,
    output logic           err,
    input  logic           halted,
    input  logic           halting,
    input  logic [PCW-1:0] saved_pc,
    input  logic [PCW-1:0] saved_npc,
    input  logic [DW-1:0]  core_rdata,
    output logic           trap_all,
    output logic           freeze_en,
    output logic [MW-1:0]  trap_sel,
    output logic           step_armed,
    output logic           brk_now,
    output logic           resume,
    output logic           acc_en,
    output logic           acc_we,
    output logic [2:0]     acc_idx,
    output logic [DW-1:0]  acc_wdata
);
    typedef struct packed {
        logic          trap_all;
        logic          freeze_en;
        logic [MW-1:0] tsel;
        logic          step;
        logic          ack;
        logic          err;
        logic [DW-1:0] rdata;
    } port_st_t;

    port_st_t pq, pd;
    logic gated, allow, wr_ok, rd_ok;

    always_comb begin
        gated = addr[3] || (addr == A_SPC) || (addr == A_SNPC);
        allow = !gated || halted;
        wr_ok = req && we && allow;
        rd_ok = req && !we && allow;

        pd       = pq;
        pd.ack   = req && allow;
        pd.err   = req && !allow;
        pd.rdata = '0;

        if (rd_ok) begin
            if (addr[3]) begin
                pd.rdata = core_rdata;
            end else begin
                unique case (addr)
                    A_CTRL:  pd.rdata = DW'({pq.freeze_en, pq.trap_all});
                    A_TSEL:  pd.rdata = DW'(pq.tsel);
                    A_CMD:   pd.rdata = DW'({halted, halting, pq.step});
                    A_SPC:   pd.rdata = DW'(saved_pc);
                    A_SNPC:  pd.rdata = DW'(saved_npc);
                    default: pd.rdata = '0;
                endcase
            end
        end

        if (wr_ok && !addr[3]) begin
            unique case (addr)
                A_CTRL: begin
                    pd.trap_all  = wdata[0];
                    pd.freeze_en = wdata[1];
                end
                A_TSEL:  pd.tsel = wdata[MW-1:0];
                A_CMD:   pd.step = wdata[1];
                default: ;
            endcase
        end

        brk_now   = wr_ok && (addr == A_CMD) && wdata[0];
        resume    = wr_ok && (addr == A_CMD) && wdata[2];
        acc_en    = req && addr[3] && halted;
        acc_we    = we;
        acc_idx   = addr[2:0];
        acc_wdata = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pq <= '0;
        end else begin
            pq <= pd;
        end
    end

    assign rdata      = pq.rdata;
    assign ack        = pq.ack;
    assign err        = pq.err;
    assign trap_all   = pq.trap_all;
    assign freeze_en  = pq.freeze_en;
    assign trap_sel   = pq.tsel;
    assign step_armed = pq.step;
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbgc_pkg::*;
#(
    parameter int NPEER = 3,
    parameter int MW    = 32,
    parameter int PCW   = 32,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_valid,
    input  logic [7:0]       trap_type,
    input  logic             err_trap,
    input  logic             step_done,
    input  logic             bus_bkpt_hit,
    input  logic [NPEER-1:0] peer_halt_in,
    input  logic             core_idle,
    input  logic [PCW-1:0]   pc,
    input  logic [PCW-1:0]   npc,
    input  logic             reg_req,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             reg_ack,
    output logic             reg_err,
    output logic             core_acc_en,
    output logic             core_acc_we,
    output logic [2:0]       core_acc_idx,
    output logic [DW-1:0]    core_acc_wdata,
    input  logic [DW-1:0]    core_acc_rdata,
    output logic             pipe_hold,
    output logic             timer_freeze,
    output logic             dbg_mode,
    output logic             peer_halt_out,
    output logic [PCW-1:0]   saved_pc,
    output logic [PCW-1:0]   saved_npc
);
    logic          trig, brk_now, resume, step_armed;
    logic          trap_all, freeze_en, halting;
    logic [MW-1:0] trap_sel;

    dbgc_trig #(.MW(MW), .NPEER(NPEER)) u_trig (
        .trap_valid   (trap_valid),
        .trap_type    (trap_type),
        .err_trap     (err_trap),
        .step_done    (step_done),
        .step_armed   (step_armed),
        .bus_bkpt_hit (bus_bkpt_hit),
        .peer_halt_in (peer_halt_in),
        .brk_now      (brk_now),
        .trap_all     (trap_all),
        .trap_sel     (trap_sel),
        .trig         (trig)
    );

    dbgc_core #(.PCW(PCW)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .trig         (trig),
        .resume       (resume),
        .core_idle    (core_idle),
        .freeze_en    (freeze_en),
        .pc           (pc),
        .npc          (npc),
        .pipe_hold    (pipe_hold),
        .halting      (halting),
        .halted       (dbg_mode),
        .timer_freeze (timer_freeze),
        .peer_out     (peer_halt_out),
        .saved_pc     (saved_pc),
        .saved_npc    (saved_npc)
    );

    dbgc_port #(.MW(MW), .PCW(PCW), .DW(DW)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (reg_req),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .ack        (reg_ack),
        .err        (reg_err),
        .halted     (dbg_mode),
        .halting    (halting),
        .saved_pc   (saved_pc),
        .saved_npc  (saved_npc),
        .core_rdata (core_acc_rdata),
        .trap_all   (trap_all),
        .freeze_en  (freeze_en),
        .trap_sel   (trap_sel),
        .step_armed (step_armed),
        .brk_now    (brk_now),
        .resume     (resume),
        .acc_en     (core_acc_en),
        .acc_we     (core_acc_we),
        .acc_idx    (core_acc_idx),
        .acc_wdata  (core_acc_wdata)
    );
endmodule

// File: rtl/dbgc_chk.sv
module dbgc_chk #(
    parameter int PCW = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           trap_valid,
    input logic [7:0]     trap_type,
    input logic           reg_req,
    input logic           reg_we,
    input logic [3:0]     reg_addr,
    input logic           wd_brk,
    input logic           wd_resume,
    input logic           reg_err,
    input logic           core_acc_en,
    input logic           pipe_hold,
    input logic           timer_freeze,
    input logic           dbg_mode,
    input logic           peer_halt_out,
    input logic [PCW-1:0] saved_pc
);
    logic gated_req;
    assign gated_req = reg_req && (reg_addr[3] || reg_addr == 4'h4 || reg_addr == 4'h5);

    a_r1_sw_bkpt_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid && trap_type == 8'h81 && !pipe_hold) |=> pipe_hold);

    a_r3_break_now: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_addr == 4'h2 && wd_brk && !pipe_hold) |=> pipe_hold);

    a_r7_peer_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        peer_halt_out |=> !peer_halt_out);

    a_r9_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_hold |=> (!pipe_hold || $stable(saved_pc)));

    a_r10_freeze_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        timer_freeze |-> pipe_hold);

    a_r11_no_window_outside: assert property (@(posedge clk) disable iff (!rst_n)
        core_acc_en |-> dbg_mode);

    a_r11_gated_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (gated_req && !dbg_mode) |=> reg_err);

    a_r12_resume_release: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_we && reg_addr == 4'h2 && wd_resume && dbg_mode) |=> !pipe_hold);
endmodule

bind dbg_halt_ctrl dbgc_chk #(.PCW(PCW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_valid    (trap_valid),
    .trap_type     (trap_type),
    .reg_req       (reg_req),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .wd_brk        (reg_wdata[0]),
    .wd_resume     (reg_wdata[2]),
    .reg_err       (reg_err),
    .core_acc_en   (core_acc_en),
    .pipe_hold     (pipe_hold),
    .timer_freeze  (timer_freeze),
    .dbg_mode      (dbg_mode),
    .peer_halt_out (peer_halt_out),
    .saved_pc      (saved_pc)
);

// File: tb/dbg_halt_ctrl_bench.sv
module dbg_halt_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_valid = 1'b0;
    logic [7:0]  trap_type = '0;
    logic        err_trap = 1'b0, step_done = 1'b0, bus_bkpt_hit = 1'b0;
    logic [2:0]  peer_halt_in = '0;
    logic        core_idle = 1'b1;
    logic [31:0] pc = '0, npc = '0;
    logic        reg_req = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_ack, reg_err;
    logic        core_acc_en, core_acc_we;
    logic [2:0]  core_acc_idx;
    logic [31:0] core_acc_wdata, core_acc_rdata;
    logic        pipe_hold, timer_freeze, dbg_mode, peer_halt_out;
    logic [31:0] saved_pc, saved_npc;

    int checks = 0;
    int errors = 0;

    logic        r_ack, r_err, a_en, a_we;
    logic [31:0] r_data, a_wd;
    logic [2:0]  a_idx;

    always #5 clk = ~clk;

    assign core_acc_rdata = 32'hC0DE_0000 | {29'b0, core_acc_idx};

    dbg_halt_ctrl u_dbg_halt_ctrl (.*);

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_acc(input logic w, input logic [3:0] a, input logic [31:0] d);
        reg_req = 1'b1; reg_we = w; reg_addr = a; reg_wdata = d;
        #1;
        a_en = core_acc_en; a_we = core_acc_we; a_idx = core_acc_idx; a_wd = core_acc_wdata;
        tick();
        r_ack = reg_ack; r_err = reg_err; r_data = reg_rdata;
        reg_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic pulse_trap(input logic [7:0] t);
        trap_valid = 1'b1; trap_type = t;
        tick();
        trap_valid = 1'b0;
    endtask

    task automatic do_resume(input string tag);
        reg_acc(1'b1, 4'h2, 32'h4);
        chk({tag, " resume drops hold"}, {31'b0, pipe_hold}, 32'd0);
        chk({tag, " resume drops dbg_mode"}, {31'b0, dbg_mode}, 32'd0);
    endtask

    task automatic t_reset();
        chk("reset pipe_hold", {31'b0, pipe_hold}, 0);
        chk("reset dbg_mode", {31'b0, dbg_mode}, 0);
        chk("reset peer_halt_out", {31'b0, peer_halt_out}, 0);
        chk("reset timer_freeze", {31'b0, timer_freeze}, 0);
        reg_acc(1'b0, 4'h0, 0);
        chk("R11 ctrl read ack while running", {31'b0, r_ack}, 1);
        chk("reset ctrl value", r_data, 0);
    endtask

    task automatic t_sw_bkpt();
        pulse_trap(8'h82);
        chk("R1 ta 2 ignored", {31'b0, pipe_hold}, 0);
        pc = 32'h4000_1000; npc = 32'h4000_1004;
        pulse_trap(8'h81);
        chk("R1 ta 1 raises hold", {31'b0, pipe_hold}, 1);
        chk("R7 peer pulse on entry", {31'b0, peer_halt_out}, 1);
        pc = 32'h4000_2000; npc = 32'h4000_2004;
        tick();
        chk("R7 peer pulse single cycle", {31'b0, peer_halt_out}, 0);
        chk("R11 dbg_mode after idle", {31'b0, dbg_mode}, 1);
        reg_acc(1'b0, 4'h4, 0);
        chk("R9 saved pc", r_data, 32'h4000_1000);
        reg_acc(1'b0, 4'h5, 0);
        chk("R9 saved npc", r_data, 32'h4000_1004);
        reg_acc(1'b0, 4'h2, 0);
        chk("R12 status halted", r_data, 32'h4);
        do_resume("R12");
    endtask

    task automatic t_watch();
        pc = 32'h0000_0100; npc = 32'h0000_0104;
        pulse_trap(8'h0B);
        chk("R2 watchpoint raises hold", {31'b0, pipe_hold}, 1);
        tick();
        pc = 32'h0000_0900; npc = 32'h0000_0904;
        pulse_trap(8'h81);
        bus_bkpt_hit = 1'b1; tick(); bus_bkpt_hit = 1'b0;
        chk("R9 pc kept over later trigger", saved_pc, 32'h0000_0100);
        chk("R9 npc kept over later trigger", saved_npc, 32'h0000_0104);
        do_resume("R2");
    endtask

    task automatic t_brk_now();
        reg_acc(1'b1, 4'h2, 32'h1);
        chk("R3 break now raises hold", {31'b0, pipe_hold}, 1);
        tick();
        do_resume("R3");
    endtask

    task automatic t_err();
        err_trap = 1'b1; tick(); err_trap = 1'b0;
        chk("R4 error trap raises hold", {31'b0, pipe_hold}, 1);
        tick();
        do_resume("R4");
    endtask

    task automatic t_sel();
        pulse_trap(8'h05);
        chk("R5 unselected trap ignored", {31'b0, pipe_hold}, 0);
        reg_acc(1'b1, 4'h1, 32'h0000_0020);
        pulse_trap(8'h06);
        chk("R5 neighbour trap ignored", {31'b0, pipe_hold}, 0);
        pulse_trap(8'h05);
        chk("R5 selected trap enters", {31'b0, pipe_hold}, 1);
        tick();
        do_resume("R5");
        reg_acc(1'b1, 4'h1, 32'h0);
        reg_acc(1'b1, 4'h0, 32'h1);
        pulse_trap(8'h11);
        chk("R5 all-traps enters", {31'b0, pipe_hold}, 1);
        tick();
        do_resume("R5");
        reg_acc(1'b1, 4'h0, 32'h0);
    endtask

    task automatic t_step();
        step_done = 1'b1; tick(); step_done = 1'b0;
        chk("R6 step_done ignored unarmed", {31'b0, pipe_hold}, 0);
        reg_acc(1'b1, 4'h2, 32'h1);
        tick();
        reg_acc(1'b1, 4'h2, 32'h6);
        chk("R6 step resume drops hold", {31'b0, pipe_hold}, 0);
        reg_acc(1'b0, 4'h2, 0);
        chk("R6 step flag reads back", r_data, 32'h1);
        step_done = 1'b1; tick(); step_done = 1'b0;
        chk("R6 step_done re-enters", {31'b0, pipe_hold}, 1);
        tick();
        do_resume("R6");
        step_done = 1'b1; tick(); step_done = 1'b0;
        chk("R6 step cleared by plain resume", {31'b0, pipe_hold}, 0);
    endtask

    task automatic t_peer_bus();
        peer_halt_in = 3'b010; tick(); peer_halt_in = '0;
        chk("R7 peer notice enters", {31'b0, pipe_hold}, 1);
        tick();
        do_resume("R7");
        bus_bkpt_hit = 1'b1; tick(); bus_bkpt_hit = 1'b0;
        chk("R8 bus breakpoint enters", {31'b0, pipe_hold}, 1);
        tick();
        do_resume("R8");
    endtask

    task automatic t_freeze();
        reg_acc(1'b1, 4'h2, 32'h1);
        chk("R10 no freeze when disabled", {31'b0, timer_freeze}, 0);
        tick();
        do_resume("R10");
        reg_acc(1'b1, 4'h0, 32'h2);
        chk("R10 no freeze while running", {31'b0, timer_freeze}, 0);
        reg_acc(1'b1, 4'h2, 32'h1);
        chk("R10 freeze with hold", {31'b0, timer_freeze}, 1);
        tick();
        do_resume("R10");
        chk("R10 freeze released", {31'b0, timer_freeze}, 0);
        reg_acc(1'b1, 4'h0, 32'h0);
    endtask

    task automatic t_gate();
        reg_acc(1'b0, 4'h4, 0);
        chk("R11 saved pc refused running", {31'b0, r_err}, 1);
        chk("R11 refused read data zero", r_data, 0);
        reg_acc(1'b1, 4'h9, 32'h1234_5678);
        chk("R11 window write refused", {31'b0, r_err}, 1);
        chk("R11 no window strobe running", {31'b0, a_en}, 0);
        core_idle = 1'b0;
        reg_acc(1'b1, 4'h2, 32'h1);
        tick(); tick();
        chk("R11 not in dbg_mode before idle", {31'b0, dbg_mode}, 0);
        reg_acc(1'b0, 4'h2, 0);
        chk("R12 status halting", r_data, 32'h2);
        reg_acc(1'b0, 4'h8, 0);
        chk("R11 window refused before idle", {31'b0, r_err}, 1);
        chk("R11 no strobe before idle", {31'b0, a_en}, 0);
        core_idle = 1'b1;
        tick();
        chk("R11 dbg_mode after idle", {31'b0, dbg_mode}, 1);
        reg_acc(1'b0, 4'hB, 0);
        chk("R11 window read ack", {31'b0, r_ack}, 1);
        chk("R11 window read data", r_data, 32'hC0DE_0003);
        reg_acc(1'b1, 4'hA, 32'hDEAD_BEEF);
        chk("R11 window write strobe", {28'b0, a_en, a_we, a_idx}, {28'b0, 1'b1, 1'b1, 3'd2});
        chk("R11 window write data", a_wd, 32'hDEAD_BEEF);
        do_resume("R11");
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sw_bkpt();
        t_watch();
        t_brk_now();
        t_err();
        t_sel();
        t_step();
        t_peer_bus();
        t_freeze();
        t_gate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule